// File: doc/BRIEF.md
# Data-Space Address Generation Unit

This unit forms the effective data-space address for the load and store operations of a small 8-bit processor core. It holds the three 16-bit pointers X, Y and Z. Each pointer is kept as a byte pair in the top six register-file entries, and the unit writes an updated value back when a mode changes the pointer. Besides direct addressing, the unit offers plain indirect, indirect plus a short unsigned displacement, indirect with pre-decrement, indirect with post-increment, and a short-port mode. The short-port mode turns a 6-bit port number into an address in the standard I/O window.

Every accepted access registers its effective address, a 2-bit region code and an out-of-range flag. Accesses to the internal SRAM go to an included SRAM model that answers after two clock cycles. All other regions complete one cycle after the start. The storage for those regions belongs to neighbouring units, so for them the unit only reports the address and region. The SRAM size is a parameter (512 or 1024 bytes), and the SRAM begins at 0x0100.

Top module: `agu_top`

## Requirements
- R1: The region code classifies an address: 0x0000–0x001F gives 0 (general registers), 0x0020–0x005F gives 1 (standard I/O), 0x0060–0x00FF gives 2 (extended I/O), and 0x0100 upward gives 3 (SRAM).
- R2: Mode 0 (direct) uses the full 16-bit address input as the effective address.
- R3: Mode 1 (indirect) uses the selected pointer as the address and leaves it unchanged. Selector 0 is X, 1 is Y, and 2 or 3 is Z.
- R4: Mode 2 adds the unsigned 6-bit displacement (0–63) to Y or Z. With X selected, the displacement is ignored and the address is X.
- R5: Mode 3 (pre-decrement) subtracts one from the pointer, uses the result as the address and writes it back. 0x0000 wraps to 0xFFFF.
- R6: Mode 4 (post-increment) uses the pointer as the address and then writes back the pointer plus one. 0xFFFF wraps to 0x0000.
- R7: Register entry 26+2p holds the low byte of pointer p and entry 27+2p holds its high byte (p = 0 X, 1 Y, 2 Z). A byte write to one of these entries updates only that half of the pointer. A pointer write-back in the same cycle takes priority.
- R8: Mode 5 (short port) maps port n (0–63) to address n + 0x20, which always falls in region 1.
- R9: An in-range SRAM access raises done in the second cycle after the start edge and keeps busy high in the first. A write is stored, and a later read returns the stored byte on the read data output while done is high.
- R10: An address above 0x00FF + SRAM_BYTES sets the out-of-range flag and completes one cycle after the start. A write to it changes no SRAM byte, and a read of it returns 0x00.
- R11: An access to region 0, 1 or 2 completes one cycle after the start and returns 0x00 on the read data output.
- R12: A start while busy is high is ignored: no pointer changes and the registered address stays the same.
- R13: After reset all pointers read 0x0000, and done and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start an access this cycle |
| mode_i | input | 3 | Addressing mode code (0–5) |
| ptr_sel_i | input | 2 | Pointer selector |
| disp_i | input | 6 | Unsigned displacement |
| dir_addr_i | input | 16 | Direct address |
| port_i | input | 6 | Short port number |
| we_i | input | 1 | Access is a write |
| wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Register-file byte write |
| reg_idx_i | input | 5 | Register-file entry number |
| reg_wdata_i | input | 8 | Register-file byte data |
| eff_addr_o | output | 16 | Registered effective address |
| region_o | output | 2 | Registered region code |
| oor_o | output | 1 | Registered out-of-range flag |
| busy_o | output | 1 | SRAM access in progress |
| done_o | output | 1 | Access completes this cycle |
| rdata_o | output | 8 | Read data while done is high |
| ptr_x_o | output | 16 | Current X pointer |
| ptr_y_o | output | 16 | Current Y pointer |
| ptr_z_o | output | 16 | Current Z pointer |

## Verification
The bench probes the four region boundaries on both sides. An off-by-one compare would give 0x005F or 0x0100 the wrong region code. It drives the pre-decrement and post-increment wrap at 0x0000 and 0xFFFF, and a design that saturates or leaves the pointer untouched would miss both the address and the write-back. An out-of-range write to 0x0300 is followed by a read of 0x0100. An SRAM index that merely truncates the address would alias onto that byte and corrupt it. A start held during a busy SRAM access checks that a second post-increment is not silently taken.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef logic [15:0] addr_t;

    localparam int NPTR     = 3;
    localparam int PTR_REG0 = 26;

    localparam addr_t IO_BASE  = 16'h0020;
    localparam addr_t XIO_BASE = 16'h0060;
    localparam addr_t RAM_BASE = 16'h0100;

    typedef enum logic [2:0] {
        MD_DIRECT  = 3'd0,
        MD_IND     = 3'd1,
        MD_DISP    = 3'd2,
        MD_PREDEC  = 3'd3,
        MD_POSTINC = 3'd4,
        MD_PORT    = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        SEL_X = 2'd0,
        SEL_Y = 2'd1,
        SEL_Z = 2'd2
    } psel_e;

    typedef enum logic [1:0] {
        RG_GPR = 2'd0,
        RG_IO  = 2'd1,
        RG_XIO = 2'd2,
        RG_RAM = 2'd3
    } region_e;

    typedef struct packed {
        addr_t ea;
        addr_t wb_val;
        logic  wb_en;
    } calc_t;

    function automatic region_e region_of(addr_t a);
        if (a < IO_BASE)       return RG_GPR;
        else if (a < XIO_BASE) return RG_IO;
        else if (a < RAM_BASE) return RG_XIO;
        else                   return RG_RAM;
    endfunction

endpackage

// File: rtl/agu_ptr_regs.sv
module agu_ptr_regs
    import agu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_we_i,
    input  logic [4:0]           byte_idx_i,
    input  logic [7:0]           byte_wdata_i,
    input  logic                 wb_en_i,
    input  logic [1:0]           wb_sel_i,
    input  addr_t                wb_val_i,
    output logic [NPTR-1:0][15:0] ptr_o
);
    localparam int NBYTES = 2 * NPTR;

    logic [4:0] off;
    logic       hit;
    logic [7:0] bytes_q [NBYTES];

    assign off = byte_idx_i - 5'(PTR_REG0);
    assign hit = (byte_idx_i >= 5'(PTR_REG0)) && (off < 5'(NBYTES));

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                bytes_q[g] <= 8'h00;
            else if (wb_en_i && wb_sel_i == 2'(g / 2))
                bytes_q[g] <= wb_val_i[8*(g%2) +: 8];
            else if (byte_we_i && hit && off == 5'(g))
                bytes_q[g] <= byte_wdata_i;
        end
    end

    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
        assign ptr_o[p] = {bytes_q[2*p+1], bytes_q[2*p]};
    end

    // write-back value lands in the selected pair on the next edge
    p_wb_lands_r7: assert property (@(posedge clk) disable iff (rst)
        wb_en_i |=> ptr_o[$past(wb_sel_i)] == $past(wb_val_i));

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
(
    input  mode_e       mode_i,
    input  psel_e       sel_i,
    input  logic [5:0]  disp_i,
    input  addr_t       dir_i,
    input  logic [5:0]  port_i,
    input  addr_t       ptr_i,
    output calc_t       calc_o
);
    always_comb begin
        calc_o.ea     = ptr_i;
        calc_o.wb_val = ptr_i;
        calc_o.wb_en  = 1'b0;
        case (mode_i)
            MD_DIRECT: calc_o.ea = dir_i;
            MD_IND:    calc_o.ea = ptr_i;
            MD_DISP: begin
                if (sel_i != SEL_X)
                    calc_o.ea = ptr_i + {10'd0, disp_i};
            end
            MD_PREDEC: begin
                calc_o.ea     = ptr_i - 16'd1;
                calc_o.wb_val = ptr_i - 16'd1;
                calc_o.wb_en  = 1'b1;
            end
            MD_POSTINC: begin
                calc_o.wb_val = ptr_i + 16'd1;
                calc_o.wb_en  = 1'b1;
            end
            MD_PORT:   calc_o.ea = IO_BASE + {10'd0, port_i};
            default:   calc_o.ea = dir_i;
        endcase
    end
endmodule

// File: rtl/agu_sram_model.sv
module agu_sram_model #(
    parameter int BYTES = 512
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_i,
    input  logic                     we_i,
    input  logic [$clog2(BYTES)-1:0] idx_i,
    input  logic [7:0]               wdata_i,
    output logic                     busy_o,
    output logic                     ack_o,
    output logic [7:0]               rdata_o
);
    localparam int IW = $clog2(BYTES);

    logic [7:0]    mem [BYTES];
    logic [IW-1:0] idx_q;
    logic          we_q;
    logic [7:0]    wdata_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            ack_o   <= 1'b0;
            idx_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= 8'h00;
            rdata_o <= 8'h00;
        end else begin
            ack_o <= 1'b0;
            if (phase_q) begin
                phase_q <= 1'b0;
                ack_o   <= 1'b1;
                rdata_o <= we_q ? 8'h00 : mem[idx_q];
            end else if (req_i) begin
                phase_q <= 1'b1;
                idx_q   <= idx_i;
                we_q    <= we_i;
                wdata_q <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && phase_q && we_q)
            mem[idx_q] <= wdata_q;
    end

    assign busy_o = phase_q;

    // two-cycle handshake: busy first cycle, acknowledge second
    p_two_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (req_i && !busy_o) |=> (busy_o && !ack_o) ##1 (ack_o && !busy_o));

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int SRAM_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [2:0]  mode_i,
    input  logic [1:0]  ptr_sel_i,
    input  logic [5:0]  disp_i,
    input  logic [15:0] dir_addr_i,
    input  logic [5:0]  port_i,
    input  logic        we_i,
    input  logic [7:0]  wdata_i,
    input  logic        reg_we_i,
    input  logic [4:0]  reg_idx_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [15:0] eff_addr_o,
    output logic [1:0]  region_o,
    output logic        oor_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [7:0]  rdata_o,
    output logic [15:0] ptr_x_o,
    output logic [15:0] ptr_y_o,
    output logic [15:0] ptr_z_o
);
    localparam int IW = $clog2(SRAM_BYTES);

    logic [NPTR-1:0][15:0] ptrs;
    logic [1:0]  sel_idx;
    addr_t       ptr_cur;
    calc_t       calc;
    region_e     reg_now;
    addr_t       ram_off;
    logic        oor_now;
    logic        accept;
    logic        ram_req;
    logic        ram_busy, ram_ack;
    logic [7:0]  ram_rdata;
    logic        fast_done_q;

    assign sel_idx = (ptr_sel_i == 2'd3) ? 2'd2 : ptr_sel_i;
    assign ptr_cur = ptrs[sel_idx];

    agu_ptr_regs u_ptrs (
        .clk          (clk),
        .rst          (rst),
        .byte_we_i    (reg_we_i),
        .byte_idx_i   (reg_idx_i),
        .byte_wdata_i (reg_wdata_i),
        .wb_en_i      (accept && calc.wb_en),
        .wb_sel_i     (sel_idx),
        .wb_val_i     (calc.wb_val),
        .ptr_o        (ptrs)
    );

    agu_addr_calc u_calc (
        .mode_i (mode_e'(mode_i)),
        .sel_i  (psel_e'(ptr_sel_i)),
        .disp_i (disp_i),
        .dir_i  (dir_addr_i),
        .port_i (port_i),
        .ptr_i  (ptr_cur),
        .calc_o (calc)
    );

    assign reg_now = region_of(calc.ea);
    assign ram_off = calc.ea - RAM_BASE;
    assign oor_now = (reg_now == RG_RAM) && (ram_off >= 16'(SRAM_BYTES));
    assign accept  = start_i && !busy_o;
    assign ram_req = accept && (reg_now == RG_RAM) && !oor_now;

    agu_sram_model #(.BYTES(SRAM_BYTES)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .req_i   (ram_req),
        .we_i    (we_i),
        .idx_i   (ram_off[IW-1:0]),
        .wdata_i (wdata_i),
        .busy_o  (ram_busy),
        .ack_o   (ram_ack),
        .rdata_o (ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            eff_addr_o  <= 16'h0000;
            region_o    <= RG_GPR;
            oor_o       <= 1'b0;
            fast_done_q <= 1'b0;
        end else begin
            fast_done_q <= accept && !ram_req;
            if (accept) begin
                eff_addr_o <= calc.ea;
                region_o   <= reg_now;
                oor_o      <= oor_now;
            end
        end
    end

    assign busy_o  = ram_busy;
    assign done_o  = fast_done_q || ram_ack;
    assign rdata_o = ram_ack ? ram_rdata : 8'h00;
    assign ptr_x_o = ptrs[0];
    assign ptr_y_o = ptrs[1];
    assign ptr_z_o = ptrs[2];

    p_port_window_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && mode_i == MD_PORT) |=> region_o == RG_IO);

    p_disp_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && mode_i == MD_DISP) |-> (calc.ea - ptr_cur) <= 16'd63);

    p_oor_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (done_o && oor_o) |-> rdata_o == 8'h00);

    p_ignore_busy_r12: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !reg_we_i) |=> ($stable(ptr_x_o) && $stable(ptr_y_o)
                                   && $stable(ptr_z_o) && $stable(eff_addr_o)));

endmodule

// File: tb/sim_agu_top.sv
module sim_agu_top;
    import agu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [1:0]  ptr_sel_i = 2'd0;
    logic [5:0]  disp_i = 6'd0;
    logic [15:0] dir_addr_i = 16'h0;
    logic [5:0]  port_i = 6'd0;
    logic        we_i = 1'b0;
    logic [7:0]  wdata_i = 8'h0;
    logic        reg_we_i = 1'b0;
    logic [4:0]  reg_idx_i = 5'd0;
    logic [7:0]  reg_wdata_i = 8'h0;
    logic [15:0] eff_addr_o;
    logic [1:0]  region_o;
    logic        oor_o, busy_o, done_o;
    logic [7:0]  rdata_o;
    logic [15:0] ptr_x_o, ptr_y_o, ptr_z_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_rd;

    always #5 clk = ~clk;

    agu_top u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_ptr(input int p, input logic [15:0] v);
        @(negedge clk);
        reg_we_i = 1'b1; reg_idx_i = 5'(26 + 2*p); reg_wdata_i = v[7:0];
        @(negedge clk);
        reg_idx_i = 5'(27 + 2*p); reg_wdata_i = v[15:8];
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic run(input string tag, input mode_e m, input logic [1:0] sel,
                       input logic [5:0] d, input logic [15:0] a, input logic [5:0] pn,
                       input logic w, input logic [7:0] wd,
                       input logic [15:0] exp_ea, input logic [1:0] exp_rg, input logic exp_oor);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; ptr_sel_i = sel; disp_i = d;
        dir_addr_i = a; port_i = pn; we_i = w; wdata_i = wd;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " addr"}, 32'(eff_addr_o), 32'(exp_ea));
        chk({tag, " region"}, 32'(region_o), 32'(exp_rg));
        chk({tag, " oor"}, 32'(oor_o), 32'(exp_oor));
        if (exp_rg == 2'd3 && !exp_oor) begin
            chk({tag, " R9 busy"}, 32'({busy_o, done_o}), 32'h2);
            @(negedge clk);
            chk({tag, " R9 done"}, 32'({busy_o, done_o}), 32'h1);
        end else begin
            chk({tag, " R11 done"}, 32'(done_o), 32'h1);
        end
        last_rd = rdata_o;
    endtask

    task automatic t_reset;
        chk("R13 ptrs", {ptr_x_o ^ ptr_y_o ^ ptr_z_o, ptr_x_o | ptr_z_o}, 32'h0);
        chk("R13 y", 32'(ptr_y_o), 32'h0);
        chk("R13 done busy", 32'({done_o, busy_o}), 32'h0);
    endtask

    task automatic t_pairs;
        set_ptr(2, 16'hABCD);
        chk("R7 z pair", 32'(ptr_z_o), 32'hABCD);
        @(negedge clk);
        reg_we_i = 1'b1; reg_idx_i = 5'd28; reg_wdata_i = 8'h5E;
        @(negedge clk);
        reg_we_i = 1'b0;
        chk("R7 y low only", 32'(ptr_y_o), 32'h005E);
        chk("R7 x untouched", 32'(ptr_x_o), 32'h0000);
    endtask

    task automatic t_regions;
        run("R1 R2 0x1F", MD_DIRECT, 0, 0, 16'h001F, 0, 0, 0, 16'h001F, 2'd0, 0);
        chk("R11 rdata", 32'(last_rd), 32'h0);
        run("R1 0x20", MD_DIRECT, 0, 0, 16'h0020, 0, 0, 0, 16'h0020, 2'd1, 0);
        run("R1 0x5F", MD_DIRECT, 0, 0, 16'h005F, 0, 0, 0, 16'h005F, 2'd1, 0);
        run("R1 0x60", MD_DIRECT, 0, 0, 16'h0060, 0, 0, 0, 16'h0060, 2'd2, 0);
        run("R1 0xFF", MD_DIRECT, 0, 0, 16'h00FF, 0, 0, 0, 16'h00FF, 2'd2, 0);
        chk("R11 rdata xio", 32'(last_rd), 32'h0);
        run("R1 0x100", MD_DIRECT, 0, 0, 16'h0100, 0, 1, 8'h11, 16'h0100, 2'd3, 0);
    endtask

    task automatic t_indirect;
        set_ptr(0, 16'h0150);
        run("R3 ind X", MD_IND, 2'd0, 0, 0, 0, 0, 0, 16'h0150, 2'd3, 0);
        chk("R3 X kept", 32'(ptr_x_o), 32'h0150);
        set_ptr(2, 16'h0045);
        run("R3 sel3 is Z", MD_IND, 2'd3, 0, 0, 0, 0, 0, 16'h0045, 2'd1, 0);
    endtask

    task automatic t_disp;
        set_ptr(1, 16'h0200);
        run("R4 Y+63", MD_DISP, 2'd1, 6'd63, 0, 0, 0, 0, 16'h023F, 2'd3, 0);
        chk("R4 Y kept", 32'(ptr_y_o), 32'h0200);
        set_ptr(2, 16'h00F0);
        run("R4 Z+16", MD_DISP, 2'd2, 6'd16, 0, 0, 0, 0, 16'h0100, 2'd3, 0);
        run("R4 X no disp", MD_DISP, 2'd0, 6'd5, 0, 0, 0, 0, 16'h0150, 2'd3, 0);
    endtask

    task automatic t_predec;
        set_ptr(2, 16'h0101);
        run("R5 Z predec", MD_PREDEC, 2'd2, 0, 0, 0, 0, 0, 16'h0100, 2'd3, 0);
        chk("R5 Z wb", 32'(ptr_z_o), 32'h0100);
        set_ptr(0, 16'h0000);
        run("R5 X wrap", MD_PREDEC, 2'd0, 0, 0, 0, 0, 0, 16'hFFFF, 2'd3, 1);
        chk("R5 X wb wrap", 32'(ptr_x_o), 32'hFFFF);
    endtask

    task automatic t_postinc;
        set_ptr(1, 16'h01FF);
        run("R6 Y postinc", MD_POSTINC, 2'd1, 0, 0, 0, 1, 8'h5A, 16'h01FF, 2'd3, 0);
        chk("R6 Y wb", 32'(ptr_y_o), 32'h0200);
        run("R9 read 0x1FF", MD_DIRECT, 0, 0, 16'h01FF, 0, 0, 0, 16'h01FF, 2'd3, 0);
        chk("R9 rdata 0x1FF", 32'(last_rd), 32'h5A);
        set_ptr(1, 16'hFFFF);
        run("R6 Y wrap", MD_POSTINC, 2'd1, 0, 0, 0, 0, 0, 16'hFFFF, 2'd3, 1);
        chk("R6 Y wb wrap", 32'(ptr_y_o), 32'h0000);
    endtask

    task automatic t_sram;
        run("R9 wr 0x123", MD_DIRECT, 0, 0, 16'h0123, 0, 1, 8'hA5, 16'h0123, 2'd3, 0);
        run("R9 wr top", MD_DIRECT, 0, 0, 16'h02FF, 0, 1, 8'h3C, 16'h02FF, 2'd3, 0);
        run("R9 rd 0x123", MD_DIRECT, 0, 0, 16'h0123, 0, 0, 0, 16'h0123, 2'd3, 0);
        chk("R9 rdata 0x123", 32'(last_rd), 32'hA5);
        run("R9 rd top", MD_DIRECT, 0, 0, 16'h02FF, 0, 0, 0, 16'h02FF, 2'd3, 0);
        chk("R9 rdata top", 32'(last_rd), 32'h3C);
    endtask

    task automatic t_oor;
        run("R10 wr 0x300", MD_DIRECT, 0, 0, 16'h0300, 0, 1, 8'h77, 16'h0300, 2'd3, 1);
        run("R10 rd 0x300", MD_DIRECT, 0, 0, 16'h0300, 0, 0, 0, 16'h0300, 2'd3, 1);
        chk("R10 rdata zero", 32'(last_rd), 32'h00);
        run("R10 alias 0x100", MD_DIRECT, 0, 0, 16'h0100, 0, 0, 0, 16'h0100, 2'd3, 0);
        chk("R10 no alias write", 32'(last_rd), 32'h11);
    endtask

    task automatic t_port;
        run("R8 port 0", MD_PORT, 0, 0, 16'hFFFF, 6'd0, 0, 0, 16'h0020, 2'd1, 0);
        run("R8 port 63", MD_PORT, 0, 0, 16'h0000, 6'd63, 0, 0, 16'h005F, 2'd1, 0);
    endtask

    task automatic t_busy;
        set_ptr(0, 16'h0010);
        @(negedge clk);
        start_i = 1'b1; mode_i = MD_DIRECT; dir_addr_i = 16'h0123; we_i = 1'b0;
        @(negedge clk);
        mode_i = MD_POSTINC; ptr_sel_i = 2'd0;
        chk("R12 busy", 32'(busy_o), 32'h1);
        @(negedge clk);
        start_i = 1'b0;
        chk("R12 done", 32'(done_o), 32'h1);
        chk("R12 rdata", 32'(rdata_o), 32'hA5);
        chk("R12 X unchanged", 32'(ptr_x_o), 32'h0010);
        chk("R12 addr held", 32'(eff_addr_o), 32'h0123);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pairs();
        t_regions();
        t_indirect();
        t_disp();
        t_predec();
        t_postinc();
        t_sram();
        t_oor();
        t_port();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule